// File: doc/BRIEF.md
# In-Order Register Scoreboard Issue Gate

This block decides, one instruction at a time, whether a decoded instruction may leave decode and go to its function unit. It keeps one availability bit per architectural register. A register is reserved when an instruction that writes it issues. It becomes available again when a writeback for it arrives. An instruction may issue only when its destination and both source registers are available and the function unit is not busy.

The block holds one instruction. The decoder offers an instruction with a valid/ready handshake. The instruction then waits in the single-entry window until it can issue. While it waits, nothing behind it is accepted, so issue stays strictly in program order. Register 0 is a constant register and is never reserved.

Top module: `sb_issue`

## Requirements
- R1: The held instruction issues (`issue_o` high) only when the availability bits of its destination, first source and second source are all set.
- R2: At most one instruction is held. A held instruction that does not issue stays in the window with unchanged fields, and `in_ready_o` stays low, so every later instruction waits behind it.
- R3: When an instruction issues, its destination register becomes reserved from the next cycle. An instruction that then names that register as a source or destination does not issue.
- R4: A writeback (`wb_valid_i` with `wb_reg_i`) makes the register available from the next cycle. A stalled instruction that waits only on it issues one cycle after the writeback cycle.
- R5: Reads do not reserve registers. An instruction whose destination is a source of the previous instruction issues in the cycle right after that instruction, with no stall.
- R6: While `fu_busy_i` is high, nothing issues and `in_ready_o` is low when the window is occupied. The held instruction issues in the first cycle in which `fu_busy_i` is low and its registers are available.
- R7: After reset all registers are available, the window is empty, `issue_o` is 0 and `in_ready_o` is 1. Register 0 is always available and an instruction writing it reserves nothing, so back-to-back writers of register 0 issue on consecutive cycles.
- R8: If an issue and a writeback name the same register in the same cycle, the register ends reserved.
- R9: `in_ready_o` is high when the window is empty or its instruction issues in that cycle. An instruction offered with `in_valid_i` high in such a cycle is held from the next cycle. `issue_dst_o`, `issue_src1_o` and `issue_src2_o` show the held instruction's fields.
- R10: A second instruction that writes the same destination as an issued, not yet written-back instruction stalls until the cycle after that register's writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoder offers an instruction |
| in_ready_o | output | 1 | Window can take the offered instruction this cycle |
| in_dst_i | input | REG_W | Destination register number |
| in_src1_i | input | REG_W | First source register number |
| in_src2_i | input | REG_W | Second source register number |
| fu_busy_i | input | 1 | Function unit cannot accept an instruction |
| wb_valid_i | input | 1 | A result is written back this cycle |
| wb_reg_i | input | REG_W | Register written back |
| issue_o | output | 1 | Held instruction issues this cycle |
| issue_dst_o | output | REG_W | Held instruction destination |
| issue_src1_o | output | REG_W | Held instruction first source |
| issue_src2_o | output | REG_W | Held instruction second source |

## Verification
Directed sequences cover the single hazards one at a time. A read-after-write pair shows that the stall ends exactly one cycle after the writeback. A write-after-write pair shows that the destination check matters. A write-after-read pair shows that no stall is added where none is needed. A same-cycle writeback and issue on one register shows which side wins. Separate cases hold the function unit busy and use register 0 back to back. A long random phase then packs operands into a few registers, with random writebacks and busy cycles. It is compared cycle by cycle with a reference model, which exposes any mistake in the ordering between flag updates, window loads and issue.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum int unsigned {
    OPND_DST  = 0,
    OPND_SRC1 = 1,
    OPND_SRC2 = 2
  } opnd_e;
  localparam int unsigned OPND_N = 3;
endpackage

// File: rtl/sb_flags.sv
module sb_flags #(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   set_en_i,
  input  logic [REG_W-1:0]                       set_idx_i,
  input  logic                                   clr_en_i,
  input  logic [REG_W-1:0]                       clr_idx_i,
  input  logic [sb_pkg::OPND_N-1:0][REG_W-1:0]   rd_idx_i,
  output logic [sb_pkg::OPND_N-1:0]              rd_avail_o,
  output logic [NUM_REGS-1:0]                    flags_o
);
  logic [NUM_REGS-1:0] avail_q, avail_d;

  // reservation applied after release: same-register collision ends reserved
  always_comb begin
    avail_d = avail_q;
    if (set_en_i) avail_d[set_idx_i] = 1'b1;
    if (clr_en_i) avail_d[clr_idx_i] = 1'b0;
    avail_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) avail_q <= '1;
    else         avail_q <= avail_d;
  end

  for (genvar g = 0; g < sb_pkg::OPND_N; g++) begin : g_rd
    assign rd_avail_o[g] = avail_q[rd_idx_i[g]];
  end

  assign flags_o = avail_q;
endmodule

// File: rtl/sb_window.sv
module sb_window #(
  parameter int DATA_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign in_ready_o = !valid_q || pop_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        data_q  <= in_data_i;
      end else if (pop_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sb_issue.sv
module sb_issue #(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [REG_W-1:0] in_dst_i,
  input  logic [REG_W-1:0] in_src1_i,
  input  logic [REG_W-1:0] in_src2_i,
  input  logic             fu_busy_i,
  input  logic             wb_valid_i,
  input  logic [REG_W-1:0] wb_reg_i,
  output logic             issue_o,
  output logic [REG_W-1:0] issue_dst_o,
  output logic [REG_W-1:0] issue_src1_o,
  output logic [REG_W-1:0] issue_src2_o
);
  import sb_pkg::*;
  localparam int WIN_W = OPND_N * REG_W;

  logic                          win_valid;
  logic [WIN_W-1:0]              win_data;
  logic [OPND_N-1:0][REG_W-1:0]  opnd_idx;
  logic [OPND_N-1:0]             opnd_avail;
  logic [NUM_REGS-1:0]           flags;
  logic                          issue;

  sb_window #(.DATA_W(WIN_W)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  ({in_dst_i, in_src1_i, in_src2_i}),
    .pop_i      (issue),
    .valid_o    (win_valid),
    .data_o     (win_data)
  );

  assign opnd_idx[OPND_DST]  = win_data[2*REG_W +: REG_W];
  assign opnd_idx[OPND_SRC1] = win_data[REG_W +: REG_W];
  assign opnd_idx[OPND_SRC2] = win_data[0 +: REG_W];

  sb_flags #(.NUM_REGS(NUM_REGS)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (wb_valid_i),
    .set_idx_i  (wb_reg_i),
    .clr_en_i   (issue),
    .clr_idx_i  (opnd_idx[OPND_DST]),
    .rd_idx_i   (opnd_idx),
    .rd_avail_o (opnd_avail),
    .flags_o    (flags)
  );

  assign issue        = win_valid && (&opnd_avail) && !fu_busy_i;
  assign issue_o      = issue;
  assign issue_dst_o  = opnd_idx[OPND_DST];
  assign issue_src1_o = opnd_idx[OPND_SRC1];
  assign issue_src2_o = opnd_idx[OPND_SRC2];
endmodule

// File: rtl/sb_issue_chk.sv
module sb_issue_chk #(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                issue_i,
  input logic                fu_busy_i,
  input logic                win_valid_i,
  input logic [REG_W-1:0]    dst_i,
  input logic [REG_W-1:0]    src1_i,
  input logic [REG_W-1:0]    src2_i,
  input logic                wb_valid_i,
  input logic [REG_W-1:0]    wb_reg_i,
  input logic [NUM_REGS-1:0] flags_i
);
  AST_ISSUE_ALL_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (flags_i[dst_i] && flags_i[src1_i] && flags_i[src2_i])); // R1
  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_i && !issue_i) |=> (win_valid_i && $stable({dst_i, src1_i, src2_i}))); // R2
  AST_RESERVE_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && dst_i != '0) |=> !flags_i[$past(dst_i)]); // R3
  AST_WB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !(issue_i && dst_i == wb_reg_i)) |=> flags_i[$past(wb_reg_i)]); // R4
  AST_FU_BUSY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fu_busy_i |-> !issue_i); // R6
  AST_ZERO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[0]); // R7
  AST_ISSUE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && wb_valid_i && wb_reg_i == dst_i && dst_i != '0) |=> !flags_i[$past(dst_i)]); // R8
endmodule

bind sb_issue sb_issue_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .issue_i     (issue_o),
  .fu_busy_i   (fu_busy_i),
  .win_valid_i (win_valid),
  .dst_i       (issue_dst_o),
  .src1_i      (issue_src1_o),
  .src2_i      (issue_src2_o),
  .wb_valid_i  (wb_valid_i),
  .wb_reg_i    (wb_reg_i),
  .flags_i     (flags)
);

// File: tb/sb_issue_tb.sv
module sb_issue_tb;
  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          in_valid = 1'b0, fu_busy = 1'b0, wb_valid = 1'b0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0, wb_reg = '0;
  logic          in_ready, issue;
  logic [RW-1:0] o_dst, o_src1, o_src2;

  sb_issue #(.NUM_REGS(NREG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_dst_i(in_dst), .in_src1_i(in_src1), .in_src2_i(in_src2),
    .fu_busy_i(fu_busy), .wb_valid_i(wb_valid), .wb_reg_i(wb_reg),
    .issue_o(issue), .issue_dst_o(o_dst), .issue_src1_o(o_src1), .issue_src2_o(o_src2)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit [NREG-1:0] m_av = '1;
  bit            m_v  = 0;
  int            m_d = 0, m_a = 0, m_b = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_issue();
    return m_v && m_av[m_d] && m_av[m_a] && m_av[m_b] && !fu_busy;
  endfunction

  task automatic set_in(bit v, int d, int a, int b, bit fu, bit wv, int wr);
    in_valid = v; in_dst = RW'(d); in_src1 = RW'(a); in_src2 = RW'(b);
    fu_busy = fu; wb_valid = wv; wb_reg = RW'(wr);
    #1;
  endtask

  // compare with model, then advance one clock
  task automatic step(string tag);
    bit ei, er;
    bit [NREG-1:0] nav;
    ei = m_issue();
    er = !m_v || ei;
    chk(issue === ei, tag, "issue_o", int'(issue), int'(ei));
    chk(in_ready === er, "R9", "in_ready_o", int'(in_ready), int'(er));
    if (m_v) begin
      chk(int'(o_dst) == m_d && int'(o_src1) == m_a && int'(o_src2) == m_b, "R9",
          "held dst", int'(o_dst), m_d);
    end
    nav = m_av;
    if (wb_valid) nav[wb_reg] = 1'b1;
    if (ei) nav[m_d] = 1'b0;
    nav[0] = 1'b1;
    @(posedge clk);
    m_av = nav;
    if (in_valid && er) begin
      m_v = 1; m_d = int'(in_dst); m_a = int'(in_src1); m_b = int'(in_src2);
    end else if (ei) m_v = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    chk(issue === 1'b0, "R7", "issue_o in reset", int'(issue), 0);
    chk(in_ready === 1'b1, "R7", "in_ready_o in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // RAW: stall until one cycle after writeback (R1 R3 R4)
    set_in(1, 3, 1, 2, 0, 0, 0); step("R1");
    set_in(1, 4, 3, 0, 0, 0, 0);
    chk(issue === 1'b1, "R1", "producer issue", int'(issue), 1); step("R1");
    set_in(0, 0, 0, 0, 0, 0, 0);
    chk(issue === 1'b0, "R3", "consumer stall", int'(issue), 0); step("R3");
    set_in(0, 0, 0, 0, 0, 1, 3);
    chk(issue === 1'b0, "R4", "stall in wb cycle", int'(issue), 0); step("R4");
    set_in(0, 0, 0, 0, 0, 0, 0);
    chk(issue === 1'b1, "R4", "issue after wb", int'(issue), 1); step("R4");
    set_in(0, 0, 0, 0, 0, 1, 4); step("R4");

    // WAW (R10)
    set_in(1, 5, 0, 0, 0, 0, 0); step("R10");
    set_in(1, 5, 0, 0, 0, 0, 0); step("R10");
    for (int i = 0; i < 3; i++) begin
      set_in(0, 0, 0, 0, 0, 0, 0);
      chk(issue === 1'b0, "R10", "second writer stall", int'(issue), 0);
      chk(in_ready === 1'b0, "R2", "blocked window", int'(in_ready), 0);
      step("R10");
    end
    set_in(0, 0, 0, 0, 0, 1, 5);
    chk(issue === 1'b0, "R10", "stall in wb cycle", int'(issue), 0); step("R10");
    set_in(0, 0, 0, 0, 0, 0, 0);
    chk(issue === 1'b1, "R10", "second writer issues", int'(issue), 1); step("R10");
    set_in(0, 0, 0, 0, 0, 1, 5); step("R10");

    // same-cycle issue and writeback (R8)
    set_in(1, 6, 0, 0, 0, 0, 0); step("R8");
    set_in(1, 1, 6, 0, 0, 1, 6); step("R8");
    set_in(0, 0, 0, 0, 0, 0, 0);
    chk(issue === 1'b0, "R8", "reservation wins", int'(issue), 0); step("R8");
    set_in(0, 0, 0, 0, 0, 1, 6); step("R8");
    set_in(0, 0, 0, 0, 0, 0, 0); step("R8");
    set_in(0, 0, 0, 0, 0, 1, 1); step("R8");

    // function unit busy (R6)
    set_in(1, 2, 0, 0, 0, 0, 0); step("R6");
    set_in(1, 9, 0, 0, 1, 0, 0);
    chk(issue === 1'b0, "R6", "busy blocks issue", int'(issue), 0);
    chk(in_ready === 1'b0, "R6", "busy blocks accept", int'(in_ready), 0); step("R6");
    set_in(0, 0, 0, 0, 0, 0, 0);
    chk(issue === 1'b1, "R6", "issue after busy", int'(issue), 1); step("R6");
    set_in(0, 0, 0, 0, 0, 1, 2); step("R6");

    // WAR: no stall (R5)
    set_in(1, 3, 7, 0, 0, 0, 0); step("R5");
    set_in(1, 7, 0, 0, 0, 0, 0); step("R5");
    set_in(0, 0, 0, 0, 0, 0, 0);
    chk(issue === 1'b1, "R5", "anti-dependent issue", int'(issue), 1); step("R5");
    set_in(0, 0, 0, 0, 0, 1, 3); step("R5");
    set_in(0, 0, 0, 0, 0, 1, 7); step("R5");

    // register 0 never reserved (R7)
    set_in(1, 0, 0, 0, 0, 0, 0); step("R7");
    set_in(1, 0, 0, 0, 0, 0, 0); step("R7");
    set_in(0, 0, 0, 0, 0, 0, 0);
    chk(issue === 1'b1, "R7", "second r0 writer", int'(issue), 1); step("R7");

    // random phase (R1 R2 R9)
    for (int i = 0; i < 3000; i++) begin
      set_in($urandom_range(0, 9) < 7, $urandom_range(0, 7), $urandom_range(0, 7),
             $urandom_range(0, 7), $urandom_range(0, 9) < 2, $urandom_range(0, 9) < 4,
             $urandom_range(0, 7));
      step("R1");
    end
    finish_run();
  end
endmodule